// File: doc/BRIEF.md
# 100BASE-TX Transmit Scrambler and MLT-3 Line Encoder

This block sits at the transmit end of a 100 Mb/s twisted-pair physical layer. It runs on the 125 MHz bit clock. Every fifth clock it takes one 5-bit code group that has already been block-encoded. It shifts the group out one bit per clock, most significant bit first. Each serial bit is XORed with the output of an 11-bit scrambling LFSR. The scrambled stream then drives a four-state MLT-3 machine. A 1 bit moves the line to the next level of the cycle, and a 0 bit holds the current level. The result is a 2-bit signed level code for an external analog driver.

The LFSR starting state comes from a 5-bit transceiver address. Ports on the same switch or repeater therefore emit different scrambler sequences, even when they carry identical idle traffic. The block reads the address only while synchronous reset is asserted. The block itself sets the timing of the parallel load: the upstream encoder must present the next group on the cycle in which `grp_take` is high.

The MLT-3 machine has four states. `M_ZUP` is level 0 on the way up. `M_POS` is +1. `M_ZDN` is level 0 on the way down. `M_NEG` is -1. A 1 bit takes the transitions `M_ZUP`→`M_POS`, `M_POS`→`M_ZDN`, `M_ZDN`→`M_NEG` and `M_NEG`→`M_ZUP`. A 0 bit leaves each state where it is. Reset forces `M_ZUP`.

Top module: `tx_scr_mlt3`

## Requirements
- R1: When `rst` is high at a clock edge, the line code after that edge is 2'b00. The load counter restarts, so `grp_take` is high in the first cycle after reset is released.
- R2: `grp_take` is high in exactly one cycle out of every five. The high cycles are 0, 5, 10 and so on, counted from the first cycle after reset.
- R3: In a cycle where `grp_take` is high, `grp_data` is captured. That cycle serializes `grp_data[4]`, and the following four cycles serialize bits 3, 2, 1 and 0, one bit per clock.
- R4: The scrambler is an 11-bit Fibonacci LFSR for x^11 + x^9 + 1, with state s[10:0]. The key bit of each cycle is s[10]. The next state is {s[9:0], s[10]^s[8]}. Each serial bit is XORed with the key bit of its own cycle, and the LFSR advances on every cycle that is not in reset.
- R5: Reset loads the seed. Bits s[10:6] and s[5:1] each take addr[4:0], and s[0] takes addr[4]. If the result is all zeros, the seed is forced to 11'b000_0000_0001. The LFSR state is never all zeros.
- R6: Changes on `phy_addr` while `rst` is low have no effect on the line output.
- R7: A scrambled 1 advances the level through 0, +1, 0, -1 and back to 0. A scrambled 0 holds the level. The level is registered, so it shows the effect of a bit one clock after that bit's cycle. The line never steps directly between +1 and -1.
- R8: The line code is 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1. The code 2'b10 never appears.
- R9: With identical input data, two different non-zero addresses produce different line sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst | input | 1 | Synchronous reset, active high; loads the address-derived seed |
| phy_addr | input | 5 | Transceiver address used to form the scrambler seed |
| grp_data | input | 5 | Encoded code group, captured while `grp_take` is high |
| grp_take | output | 1 | High in the cycle in which `grp_data` is captured |
| line_lvl | output | 2 | MLT-3 level: 01 = +1, 00 = 0, 11 = -1 |

## Verification
Some properties are checked by assertions on every cycle: the load counter stays in range and `grp_take` never repeats in consecutive cycles; the LFSR never holds all zeros; a scrambled 0 holds the level and a scrambled 1 changes it; the line never jumps between +1 and -1; the forbidden code never appears; and reset drives the line to 0. Other behaviour can only be shown by the bench's scenarios, where a behavioural model is compared with the line output on every clock. These are the exact bit order, the seed formed from each address including the all-zero case, the fact that the address is ignored outside reset, and the difference between the sequences of two addresses.

// File: rtl/tx_scr_pkg.sv
package tx_scr_pkg;
    localparam int GRP_W  = 5;
    localparam int ADDR_W = 5;
    localparam int LFSR_W = 11;
    localparam int TAP_LO = 8;

    typedef enum logic [1:0] {
        M_ZUP = 2'd0,
        M_POS = 2'd1,
        M_ZDN = 2'd2,
        M_NEG = 2'd3
    } mlt_st_t;

    localparam logic [1:0] LVL_P = 2'b01;
    localparam logic [1:0] LVL_Z = 2'b00;
    localparam logic [1:0] LVL_N = 2'b11;
endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
    parameter int ADDR_W = tx_scr_pkg::ADDR_W,
    parameter int LFSR_W = tx_scr_pkg::LFSR_W,
    parameter int TAP_LO = tx_scr_pkg::TAP_LO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic              key_bit
);
    logic [LFSR_W-1:0] st_q;
    logic [LFSR_W-1:0] seed_raw;
    logic [LFSR_W-1:0] seed;

    // The address is repeated from its MSB downward across the state.
    for (genvar i = 0; i < LFSR_W; i++) begin : g_seed
        localparam int SRC = (ADDR_W - 1) - ((LFSR_W - 1 - i) % ADDR_W);
        assign seed_raw[i] = addr[SRC];
    end

    assign seed = (seed_raw == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : seed_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= seed;
        end else begin
            st_q <= {st_q[LFSR_W-2:0], st_q[LFSR_W-1] ^ st_q[TAP_LO]};
        end
    end

    assign key_bit = st_q[LFSR_W-1];

    // R5: the LFSR is never stuck in the all-zero state
    a_r5_state_nonzero: assert property (@(posedge clk) disable iff (rst)
        st_q != '0);
endmodule

// File: rtl/grp_piso.sv
module grp_piso #(
    parameter int GRP_W = tx_scr_pkg::GRP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GRP_W-1:0] grp_data,
    output logic             take,
    output logic             ser_bit
);
    localparam int CW = (GRP_W > 1) ? $clog2(GRP_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(GRP_W - 1);

    logic [CW-1:0]    cnt_q;
    logic [GRP_W-1:0] sh_q;

    assign take    = (cnt_q == '0);
    assign ser_bit = take ? grp_data[GRP_W-1] : sh_q[GRP_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            if (take) begin
                sh_q <= {grp_data[GRP_W-2:0], 1'b0};
            end else begin
                sh_q <= {sh_q[GRP_W-2:0], 1'b0};
            end
        end
    end

    // R2: the counter stays inside one group period
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    // R2: the load strobe never repeats in consecutive cycles
    a_r2_take_single: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);
endmodule

// File: rtl/mlt3_fsm.sv
module mlt3_fsm
    import tx_scr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_in,
    output logic [1:0] lvl
);
    mlt_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= M_ZUP;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (bit_in) begin
            unique case (st_q)
                M_ZUP: st_d = M_POS;
                M_POS: st_d = M_ZDN;
                M_ZDN: st_d = M_NEG;
                M_NEG: st_d = M_ZUP;
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            M_POS:   lvl = LVL_P;
            M_NEG:   lvl = LVL_N;
            default: lvl = LVL_Z;
        endcase
    end

    // R7: a scrambled 0 leaves the level unchanged
    a_r7_hold_on_zero: assert property (@(posedge clk) disable iff (rst)
        !bit_in |=> $stable(lvl));
    // R7: a scrambled 1 always changes the level
    a_r7_move_on_one: assert property (@(posedge clk) disable iff (rst)
        bit_in |=> (lvl != $past(lvl)));
    // R7: no direct step from +1 to -1
    a_r7_no_pos_to_neg: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_P) |=> (lvl != LVL_N));
    // R7: no direct step from -1 to +1
    a_r7_no_neg_to_pos: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_N) |=> (lvl != LVL_P));
    // R8: forbidden code never driven
    a_r8_no_bad_code: assert property (@(posedge clk) disable iff (rst)
        lvl != 2'b10);
endmodule

// File: rtl/tx_scr_mlt3.sv
module tx_scr_mlt3
    import tx_scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [GRP_W-1:0]  grp_data,
    output logic              grp_take,
    output logic [1:0]        line_lvl
);
    logic ser_bit;
    logic key_bit;
    logic scr_bit;

    grp_piso #(.GRP_W(GRP_W)) u_piso (
        .clk      (clk),
        .rst      (rst),
        .grp_data (grp_data),
        .take     (grp_take),
        .ser_bit  (ser_bit)
    );

    scr_lfsr #(.ADDR_W(ADDR_W), .LFSR_W(LFSR_W), .TAP_LO(TAP_LO)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .addr    (phy_addr),
        .key_bit (key_bit)
    );

    assign scr_bit = ser_bit ^ key_bit;

    mlt3_fsm u_mlt3 (
        .clk    (clk),
        .rst    (rst),
        .bit_in (scr_bit),
        .lvl    (line_lvl)
    );

    // R1: reset returns the line to level 0
    a_r1_reset_level: assert property (@(posedge clk)
        rst |=> (line_lvl == LVL_Z));
    // R1: first cycle after reset is a load cycle
    a_r1_take_after_reset: assert property (@(posedge clk)
        (rst ##1 !rst) |-> grp_take);
endmodule

// File: tb/tx_scr_mlt3_bench.sv
module tx_scr_mlt3_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] phy_addr = 5'd0;
    logic [4:0] grp_data = 5'd0;
    logic       grp_take;
    logic [1:0] line_lvl;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // behavioural model state
    int m_lfsr [11];
    int m_cnt;
    int m_grp;
    int m_phase;
    int cap_a [60];
    int cap_b [60];

    tx_scr_mlt3 u_tx_scr_mlt3 (
        .clk      (clk),
        .rst      (rst),
        .phy_addr (phy_addr),
        .grp_data (grp_data),
        .grp_take (grp_take),
        .line_lvl (line_lvl)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic int lvl_code(int ph);
        case (ph)
            1: return 1;
            3: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R5: seed built from the address, MSB first, all-zero forced to 1
    task automatic model_reset(int a);
        int any = 0;
        for (int i = 0; i < 11; i++) begin
            int src = 4 - ((10 - i) % 5);
            m_lfsr[i] = (a >> src) & 1;
            any += m_lfsr[i];
        end
        if (any == 0) m_lfsr[0] = 1;
        m_cnt = 0;
        m_phase = 0;
    endtask

    task automatic do_reset(int a, int n);
        rst = 1'b1;
        phy_addr = 5'(a);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1 level in reset", int'(line_lvl), 0);
        end
        model_reset(a);
        rst = 1'b0;
    endtask

    // one clock: present data, predict, compare after the edge
    task automatic cyc(int data);
        int b;
        int k;
        int fb;
        grp_data = 5'(data);
        #0;
        check("R2 grp_take", int'(grp_take), (m_cnt == 0) ? 1 : 0);
        if (m_cnt == 0) m_grp = data;
        b = (m_grp >> (4 - m_cnt)) & 1;           // R3: MSB first
        k = m_lfsr[10];                            // R4: key bit
        fb = m_lfsr[10] ^ m_lfsr[8];
        for (int i = 10; i > 0; i--) m_lfsr[i] = m_lfsr[i-1];
        m_lfsr[0] = fb;
        if ((b ^ k) != 0) m_phase = (m_phase + 1) % 4;   // R7
        m_cnt = (m_cnt + 1) % 5;
        @(posedge clk);
        @(negedge clk);
        check("R7/R8 line level", int'(line_lvl), lvl_code(m_phase));
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state and take right after release
        do_reset(5'd5, 3);

        // R2 R3 R4 R7: idle zeros, pure scrambler output
        for (int i = 0; i < 60; i++) cyc(0);
        // all ones
        for (int i = 0; i < 60; i++) cyc(31);
        // alternating and walking patterns
        for (int i = 0; i < 100; i++) cyc((i % 2) ? 5'h15 : 5'h0A);
        for (int i = 0; i < 100; i++) cyc(1 << ((i / 5) % 5));
        // pseudo-random groups
        begin
            int r = 7;
            for (int i = 0; i < 300; i++) begin
                r = (r * 1103 + 12345) % 65536;
                cyc(r % 32);
            end
        end

        // R6: address changes outside reset are ignored
        for (int i = 0; i < 100; i++) begin
            phy_addr = 5'(i);
            cyc(i % 32);
        end

        // R5: all-zero address forces seed 1
        do_reset(0, 2);
        for (int i = 0; i < 120; i++) cyc(0);

        // R1: mid-group reset
        for (int i = 0; i < 7; i++) cyc(9);
        do_reset(5'd19, 1);
        for (int i = 0; i < 50; i++) cyc(i % 32);

        // R9: two addresses, same data, different sequences
        do_reset(5'd5, 2);
        for (int i = 0; i < 60; i++) begin
            cyc(0);
            cap_a[i] = int'(line_lvl);
        end
        do_reset(5'd10, 2);
        for (int i = 0; i < 60; i++) begin
            cyc(0);
            cap_b[i] = int'(line_lvl);
        end
        begin
            int diff = 0;
            for (int i = 0; i < 60; i++) if (cap_a[i] != cap_b[i]) diff++;
            check("R9 sequences differ", (diff > 0) ? 1 : 0, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule